// File: doc/BRIEF.md
# Keyed-clear watchdog timer

This watchdog counts enabled clock cycles through a prescaling divider whose output tick drives a two-stage binary counter. If software fails to write the clear key into the key register before that counter wraps, the block raises a reset request for a fixed number of cycles. After that hold it re-arms and counts again from zero. A two-bit select picks the divider period from four powers of two, so the detection time is four divider periods.

The watchdog runs from reset. Turning it off takes two writes: a write to the control register with the run bit low, then the disable key into the key register. A sticky status bit records that a watchdog reset request has occurred. Any write to the status address clears it. Only rst_ni clears the block's state.

Top module: `keyed_wdt`

## Requirements
- R1: After rst_ni the reset request and the status bit are low, and the watchdog is running.
- R2: With no key writes and en_i held high, the reset request rises on the 4*2^(DIV_BASE_LOG2+DIV_STEP_LOG2*sel_i)-th rising edge after reset release. The bench uses DIV_BASE_LOG2=2 and DIV_STEP_LOG2=2, which gives 16, 64, 256 and 1024 edges for sel_i = 0 to 3.
- R3: The reset request stays high for exactly HOLD_CYC (4) cycles. Counting then restarts from zero, so the next request rises one detection time after the request fell.
- R4: A write of 8'h4E to address 1 (the key register) clears the two-stage counter. The divider keeps running.
- R5: A write of any other non-disable value to address 1 leaves the count unchanged.
- R6: A write to address 0 with data bit 0 low, followed by a write of 8'hB1 to address 1, stops the watchdog and clears the divider and the counter. A later write to address 0 with bit 0 high restarts counting from zero on the next edge.
- R7: A write of 8'hB1 to address 1 has no effect unless a write to address 0 with bit 0 low came before it.
- R8: While en_i is low, the divider and the counter hold their value.
- R9: The status bit is set on the same edge that the reset request rises. It stays set until a write to address 2, which clears it unless a new request rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable |
| sel_i | input | 2 | Detection-time select |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 key, 2 status |
| wr_data_i | input | 8 | Write data |
| rst_req_o | output | 1 | Watchdog reset request |
| status_o | output | 1 | Sticky watchdog-reset flag |

## Verification
The bench builds the block with DIV_BASE_LOG2=2 and DIV_STEP_LOG2=2, so the four detection times are 16 to 1024 cycles instead of many thousands. With those values every select setting can be checked to its exact edge. The same values also bring within reach the restart after the hold, a clear key landing between divider ticks, and a count frozen by en_i, each within a few dozen cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_KEY  = 2'd1,
    ADDR_STAT = 2'd2
  } wdt_addr_e;

  localparam logic [DATA_W-1:0] KEY_CLEAR   = 8'h4E;
  localparam logic [DATA_W-1:0] KEY_DISABLE = 8'hB1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              run_o,
  output logic              kick_o,
  output logic              stat_clr_o
);
  logic run_q, pend_q;
  logic wr_ctrl, wr_key;

  assign wr_ctrl    = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_key     = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign kick_o     = wr_key && (wr_data_i == KEY_CLEAR);
  assign stat_clr_o = wr_en_i && (wr_addr_i == ADDR_STAT);
  assign run_o      = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (wr_ctrl) begin
      if (wr_data_i[0]) begin
        run_q  <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        pend_q <= run_q;
      end
    end else if (wr_key && (wr_data_i == KEY_DISABLE) && pend_q) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_div.sv
module wdt_div #(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned STEP_LOG2 = 2,
  parameter int unsigned SEL_W     = 2,
  localparam int unsigned N_SEL    = 1 << SEL_W,
  localparam int unsigned DIV_W    = BASE_LOG2 + STEP_LOG2 * (N_SEL - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [N_SEL-1:0] tap_full;

  for (genvar s = 0; s < N_SEL; s++) begin : g_tap
    localparam int unsigned PLOG = BASE_LOG2 + STEP_LOG2 * s;
    assign tap_full[s] = &div_q[PLOG-1:0];
  end

  assign tick_o = run_i && en_i && !clr_i && tap_full[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!run_i || clr_i)   div_q <= '0;
    else if (en_i)              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int unsigned STAGES   = 2,
  parameter int unsigned HOLD_CYC = 4,
  localparam int unsigned HOLD_W  = $clog2(HOLD_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic kick_i,
  output logic fire_o,
  output logic hold_o
);
  logic [STAGES-1:0] cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              req_q;

  assign fire_o = tick_i && !kick_i && !req_q && (&cnt_q);
  assign hold_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!run_i || kick_i || req_q)     cnt_q <= '0;
    else if (tick_i)                        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (fire_o) begin
      req_q  <= 1'b1;
      hold_q <= HOLD_W'(HOLD_CYC - 1);
    end else if (req_q) begin
      if (hold_q == '0) req_q <= 1'b0;
      else              hold_q <= hold_q - 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_BASE_LOG2 = 13,
  parameter int unsigned DIV_STEP_LOG2 = 2,
  parameter int unsigned SEL_W         = 2,
  parameter int unsigned STAGES        = 2,
  parameter int unsigned HOLD_CYC      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rst_req_o,
  output logic              status_o
);
  logic run, kick, stat_clr, tick, fire, hold;
  logic stat_q;

  wdt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .run_o(run), .kick_o(kick), .stat_clr_o(stat_clr)
  );

  wdt_div #(.BASE_LOG2(DIV_BASE_LOG2), .STEP_LOG2(DIV_STEP_LOG2), .SEL_W(SEL_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .en_i, .clr_i(hold), .sel_i, .tick_o(tick)
  );

  wdt_stage #(.STAGES(STAGES), .HOLD_CYC(HOLD_CYC)) u_stage (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .kick_i(kick),
    .fire_o(fire), .hold_o(hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= 1'b0;
    else if (fire)     stat_q <= 1'b1;
    else if (stat_clr) stat_q <= 1'b0;
  end

  assign rst_req_o = hold;
  assign status_o  = stat_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rst_req_o,
  input logic              status_o
);
  logic [7:0] run_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_len <= '0;
    else if (rst_req_o) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o);
  // R3
  req_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len <= 8'(HOLD_CYC));
  // R9
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> status_o);
  // R9
  stat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !(wr_en_i && wr_addr_i == ADDR_STAT)) |=> status_o);
  // R8
  en_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(en_i));
endmodule

bind keyed_wdt wdt_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .rst_req_o(rst_req_o), .status_o(status_o)
);

// File: tb/sim_keyed_wdt.sv
`timescale 1ns/1ps
module sim_keyed_wdt;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [1:0] sel_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       rst_req_o, status_o;

  int n_chk = 0, n_fail = 0, edges = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  keyed_wdt #(.DIV_BASE_LOG2(2), .DIV_STEP_LOG2(2)) u0 (.*);

  // detection time per select: 4 * 2^(2+2*sel)
  localparam int TAB_SEL[4] = '{0, 1, 2, 3};
  localparam int TAB_EXP[4] = '{16, 64, 256, 1024};

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: got %0b expected %0b", req, edges, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    edges++;
  endtask

  task automatic run_to(int target);
    while (edges < target) step();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset(logic [1:0] s);
    rst_ni = 1'b0; sel_i = s; en_i = 1'b1; wr_en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edges = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset(2'd0);
    chk("R1 req", rst_req_o, 1'b0);
    chk("R1 status", status_o, 1'b0);

    // R2 detection time table
    for (int i = 0; i < 4; i++) begin
      do_reset(2'(TAB_SEL[i]));
      run_to(TAB_EXP[i] - 1);
      chk("R2 before", rst_req_o, 1'b0);
      step();
      chk("R2 at", rst_req_o, 1'b1);
    end

    // R3 hold, restart; R9 status sticky and clear
    do_reset(2'd0);
    run_to(15);
    chk("R9 before", status_o, 1'b0);
    step();
    chk("R9 set", status_o, 1'b1);
    run_to(19);
    chk("R3 held", rst_req_o, 1'b1);
    step();
    chk("R3 released", rst_req_o, 1'b0);
    run_to(35);
    chk("R3 rearm before", rst_req_o, 1'b0);
    chk("R9 kept", status_o, 1'b1);
    step();
    chk("R3 rearm at", rst_req_o, 1'b1);
    wr(2'd2, 8'h00);
    chk("R9 cleared", status_o, 1'b0);

    // R4 clear key
    do_reset(2'd0);
    run_to(9);
    wr(2'd1, 8'h4E);
    run_to(23);
    chk("R4 before", rst_req_o, 1'b0);
    step();
    chk("R4 at", rst_req_o, 1'b1);

    // R5 wrong key
    do_reset(2'd0);
    run_to(9);
    wr(2'd1, 8'h4F);
    run_to(15);
    chk("R5 before", rst_req_o, 1'b0);
    step();
    chk("R5 at", rst_req_o, 1'b1);

    // R6 disable then re-enable
    do_reset(2'd0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hB1);
    run_to(200);
    chk("R6 off req", rst_req_o, 1'b0);
    chk("R6 off status", status_o, 1'b0);
    wr(2'd0, 8'h01);
    run_to(216);
    chk("R6 on before", rst_req_o, 1'b0);
    step();
    chk("R6 on at", rst_req_o, 1'b1);

    // R7 disable key without prior control write
    do_reset(2'd0);
    wr(2'd1, 8'hB1);
    run_to(15);
    chk("R7 before", rst_req_o, 1'b0);
    step();
    chk("R7 at", rst_req_o, 1'b1);

    // R8 enable low freezes the count
    do_reset(2'd0);
    run_to(6);
    en_i = 1'b0;
    run_to(26);
    chk("R8 frozen", rst_req_o, 1'b0);
    en_i = 1'b1;
    run_to(35);
    chk("R8 before", rst_req_o, 1'b0);
    step();
    chk("R8 at", rst_req_o, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule